// File: doc/BRIEF.md
# Panel Bring-Up Sequencer

This block powers up a 240x320 display driver chip without software involvement. After a start pulse it holds the panel in reset and then releases it. It writes a short run of zero words to settle the driver's bus state and reads the chip's identity register. If that register does not hold the expected code, the block stops and raises a fail flag.

When the identity matches, the block sends a fixed program of register writes. The program is kept as a short list of steps, and some steps stream register/value pairs from an on-chip table. Millisecond pauses sit between groups of writes. The block programs the display window from its column and row parameters, fills the graphics memory with zeros and switches the display on.

All traffic leaves through one request port that uses a valid/ready handshake. Each request carries an operation code and an 18-bit bus word. The block raises `bus_valid` and keeps the operation and word unchanged until the cycle in which `bus_ready` is high. The transfer happens on that edge. Back-pressure from `bus_ready` only stretches the sequence and never changes what is sent. For a read, the responder presents `bus_rdata` in the same cycle in which it raises `bus_ready`. Bus timing strobes are generated outside this block.

Top module: `panel_init_seq`

## Requirements
- R1: After reset, `init_done` and `init_fail` are 0, `panel_rst_n` is 1 and `bus_valid` is 0.
- R2: After start, `panel_rst_n` is driven low for 2 ms and then high. At least 1 ms more passes before the first bus request. No request is made while `panel_rst_n` is low.
- R3: A 16-bit word w appears on `bus_word` with w[7:0] on bits 8:1 and w[15:8] on bits 17:10, and with bits 0 and 9 set to 1. `bus_op` is 0 for an index write, 1 for a data write and 2 for a data read. A register write is an index transfer of the register number followed by a data transfer of the value.
- R4: The first bus traffic is four writes of value 0 to register 0, followed by a read of register 0. The read word is taken from `bus_rdata` bits 8:1 (low byte) and 17:10 (high byte), and bits 0 and 9 are ignored. If the word differs from DEV_CODE (0x1505), `init_fail` rises and no further request is made.
- R5: After a matching identity, the block sends, in this order: the four zero writes again; 0x0001 to 0x00A4; table group A (12 pairs); table group B (25 pairs); the four window writes; table group C (4 pairs); table group D (3 pairs); the memory clear; the closing writes.
- R6: The pauses are 10 ms after the 0x00A4 write and 100 ms after group A. There is no pause after group B. The pauses are 10 ms after group C and 40 ms after group D. One millisecond is CYC_PER_MS clock cycles.
- R7: The window writes set 0x0050 to 0xEF-(ROWS-1), 0x0051 to 0x00EF, 0x0052 to 0 and 0x0053 to COLS-1.
- R8: The memory clear writes 0 to 0x0020 and 0x0021, then COLS*WORDS_PER_LINE writes of 0 to 0x0022, then 0 to 0x0020 and 0x0021 again.
- R9: The block then writes 0x0173 to 0x0007 and waits 40 ms. It then issues one index-only transfer of the word 0x0022, waits 100 ms and raises `init_done`.
- R10: While `bus_valid` is high and `bus_ready` is low, `bus_valid`, `bus_op` and `bus_word` hold their values on the next cycle.
- R11: `init_done` and `init_fail` stay set until the next start pulse and are never high together. A start pulse while a sequence is running is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| init_start | input | 1 | Start pulse, accepted only when the block is idle |
| init_done | output | 1 | Sequence completed, sticky |
| init_fail | output | 1 | Identity mismatch, sticky |
| panel_rst_n | output | 1 | Active-low reset to the panel |
| bus_valid | output | 1 | Request present |
| bus_ready | input | 1 | Responder accepts the request this cycle |
| bus_op | output | 2 | 0 index write, 1 data write, 2 data read |
| bus_word | output | 18 | Mapped index or data word |
| bus_rdata | input | 18 | Read word, sampled on an accepted read |

## Verification
A request is visible two cycles after the step that issues it is fetched. Each pause adds its millisecond count times CYC_PER_MS cycles, plus about four cycles of step fetch and wait exit. The panel reset therefore stays low for 2 ms plus two cycles. Each delay-bearing gap between accepted transfers is expected to be the pause length plus a few cycles. The bench checks every such gap against a window from the exact millisecond count up to eight cycles beyond it, so pattern stalls on `bus_ready` stay inside the window. Word contents and their order are compared transfer by transfer against a list the bench builds from the requirements, and the fail flag is checked on the cycle after the read is accepted.

// File: rtl/pis_pkg.sv
package pis_pkg;

  typedef enum logic [1:0] {
    OP_IDX = 2'd0,
    OP_DAT = 2'd1,
    OP_RD  = 2'd2
  } bus_op_e;

  typedef enum logic [2:0] {
    SK_RST_LO,
    SK_RST_HI,
    SK_DELAY,
    SK_WRITE,
    SK_TABLE,
    SK_ID_READ,
    SK_IDX_ONLY,
    SK_END
  } step_kind_e;

  // One program step: for SK_TABLE, val is the first table row and rep the row count;
  // for SK_WRITE, rep is how many times the same pair is sent.
  typedef struct packed {
    step_kind_e  kind;
    logic [15:0] addr;
    logic [15:0] val;
    logic [31:0] rep;
  } step_t;

  localparam int STEP_AW   = 5;
  localparam int TBL_AW    = 6;
  localparam int MS_W      = 8;

  function automatic logic [17:0] pack_bus(input logic [15:0] w);
    return {w[15:8], 1'b1, w[7:0], 1'b1};
  endfunction

  function automatic logic [15:0] unpack_bus(input logic [17:0] b);
    return {b[17:10], b[8:1]};
  endfunction

  function automatic step_t mk_step(input step_kind_e k, input logic [15:0] a,
                                    input logic [15:0] v, input logic [31:0] r);
    step_t s;
    s.kind = k;
    s.addr = a;
    s.val  = v;
    s.rep  = r;
    return s;
  endfunction

endpackage

// File: rtl/pis_step_rom.sv
module pis_step_rom
  import pis_pkg::*;
#(
  parameter int COLS           = 320,
  parameter int ROWS           = 240,
  parameter int WORDS_PER_LINE = 256
) (
  input  logic [STEP_AW-1:0] idx,
  output step_t              ent
);
  localparam logic [15:0] WIN_TOP   = 16'(239 - (ROWS - 1));
  localparam logic [15:0] WIN_RIGHT = 16'(COLS - 1);
  localparam logic [31:0] FILL_N    = 32'(COLS * WORDS_PER_LINE);

  always_comb begin
    ent = mk_step(SK_END, 16'h0, 16'h0, 32'd0);
    case (idx)
      5'd0:  ent = mk_step(SK_RST_LO,   16'h0000, 16'd2,    32'd0);
      5'd1:  ent = mk_step(SK_RST_HI,   16'h0000, 16'd1,    32'd0);
      5'd2:  ent = mk_step(SK_WRITE,    16'h0000, 16'h0000, 32'd4);
      5'd3:  ent = mk_step(SK_ID_READ,  16'h0000, 16'h0000, 32'd1);
      5'd4:  ent = mk_step(SK_WRITE,    16'h0000, 16'h0000, 32'd4);
      5'd5:  ent = mk_step(SK_WRITE,    16'h00A4, 16'h0001, 32'd1);
      5'd6:  ent = mk_step(SK_DELAY,    16'h0000, 16'd10,   32'd0);
      5'd7:  ent = mk_step(SK_TABLE,    16'h0000, 16'd0,    32'd12);
      5'd8:  ent = mk_step(SK_DELAY,    16'h0000, 16'd100,  32'd0);
      5'd9:  ent = mk_step(SK_TABLE,    16'h0000, 16'd12,   32'd25);
      5'd10: ent = mk_step(SK_WRITE,    16'h0050, WIN_TOP,  32'd1);
      5'd11: ent = mk_step(SK_WRITE,    16'h0051, 16'h00EF, 32'd1);
      5'd12: ent = mk_step(SK_WRITE,    16'h0052, 16'h0000, 32'd1);
      5'd13: ent = mk_step(SK_WRITE,    16'h0053, WIN_RIGHT, 32'd1);
      5'd14: ent = mk_step(SK_TABLE,    16'h0000, 16'd37,   32'd4);
      5'd15: ent = mk_step(SK_DELAY,    16'h0000, 16'd10,   32'd0);
      5'd16: ent = mk_step(SK_TABLE,    16'h0000, 16'd41,   32'd3);
      5'd17: ent = mk_step(SK_DELAY,    16'h0000, 16'd40,   32'd0);
      5'd18: ent = mk_step(SK_WRITE,    16'h0020, 16'h0000, 32'd1);
      5'd19: ent = mk_step(SK_WRITE,    16'h0021, 16'h0000, 32'd1);
      5'd20: ent = mk_step(SK_WRITE,    16'h0022, 16'h0000, FILL_N);
      5'd21: ent = mk_step(SK_WRITE,    16'h0020, 16'h0000, 32'd1);
      5'd22: ent = mk_step(SK_WRITE,    16'h0021, 16'h0000, 32'd1);
      5'd23: ent = mk_step(SK_WRITE,    16'h0007, 16'h0173, 32'd1);
      5'd24: ent = mk_step(SK_DELAY,    16'h0000, 16'd40,   32'd0);
      5'd25: ent = mk_step(SK_IDX_ONLY, 16'h0000, 16'h0022, 32'd1);
      5'd26: ent = mk_step(SK_DELAY,    16'h0000, 16'd100,  32'd0);
      default: ;
    endcase
  end
endmodule

// File: rtl/pis_table_rom.sv
module pis_table_rom
  import pis_pkg::*;
(
  input  logic [TBL_AW-1:0] idx,
  output logic [15:0]       addr,
  output logic [15:0]       val
);
  logic [31:0] row;

  always_comb begin
    case (idx)
      // group A, rows 0..11
      6'd0:  row = 32'h0060_2700;
      6'd1:  row = 32'h0008_0808;
      6'd2:  row = 32'h0090_001A;
      6'd3:  row = 32'h0007_0001;
      6'd4:  row = 32'h0017_0001;
      6'd5:  row = 32'h0019_0000;
      6'd6:  row = 32'h0010_17B0;
      6'd7:  row = 32'h0011_0116;
      6'd8:  row = 32'h0012_0198;
      6'd9:  row = 32'h0013_1400;
      6'd10: row = 32'h0029_000C;
      6'd11: row = 32'h0012_01B8;
      // group B, rows 12..36
      6'd12: row = 32'h0030_0307;
      6'd13: row = 32'h0031_0303;
      6'd14: row = 32'h0032_0603;
      6'd15: row = 32'h0033_0202;
      6'd16: row = 32'h0034_0202;
      6'd17: row = 32'h0035_0202;
      6'd18: row = 32'h0036_1F1F;
      6'd19: row = 32'h0037_0303;
      6'd20: row = 32'h0038_0303;
      6'd21: row = 32'h0039_0603;
      6'd22: row = 32'h003A_0202;
      6'd23: row = 32'h003B_0102;
      6'd24: row = 32'h003C_0204;
      6'd25: row = 32'h003D_0000;
      6'd26: row = 32'h0001_0100;
      6'd27: row = 32'h0002_0300;
      6'd28: row = 32'h0003_5028;
      6'd29: row = 32'h0020_00EF;
      6'd30: row = 32'h0021_0000;
      6'd31: row = 32'h0004_0000;
      6'd32: row = 32'h0009_0000;
      6'd33: row = 32'h000A_0008;
      6'd34: row = 32'h000C_0000;
      6'd35: row = 32'h000D_0000;
      6'd36: row = 32'h0015_8000;
      // group C, rows 37..40
      6'd37: row = 32'h0061_0001;
      6'd38: row = 32'h0092_0100;
      6'd39: row = 32'h0093_0001;
      6'd40: row = 32'h0007_0021;
      // group D, rows 41..43
      6'd41: row = 32'h0010_16B0;
      6'd42: row = 32'h0011_0111;
      6'd43: row = 32'h0007_0061;
      default: row = 32'h0000_0000;
    endcase
    addr = row[31:16];
    val  = row[15:0];
  end
endmodule

// File: rtl/pis_ms_timer.sv
module pis_ms_timer #(
  parameter int CYC_PER_MS = 125000,
  parameter int MS_W       = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [MS_W-1:0] ms,
  output logic            idle
);
  localparam int CW = (CYC_PER_MS > 1) ? $clog2(CYC_PER_MS) : 1;
  localparam logic [CW-1:0] RELOAD = CW'(CYC_PER_MS - 1);

  logic [MS_W-1:0] ms_left;
  logic [CW-1:0]   cyc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ms_left <= '0;
      cyc     <= '0;
    end else if (load) begin
      ms_left <= ms;
      cyc     <= RELOAD;
    end else if (ms_left != '0) begin
      if (cyc == '0) begin
        cyc     <= RELOAD;
        ms_left <= ms_left - 1'b1;
      end else begin
        cyc <= cyc - 1'b1;
      end
    end
  end

  assign idle = (ms_left == '0);
endmodule

// File: rtl/panel_init_seq.sv
module panel_init_seq
  import pis_pkg::*;
#(
  parameter int          CYC_PER_MS     = 125000,
  parameter int          COLS           = 320,
  parameter int          ROWS           = 240,
  parameter int          WORDS_PER_LINE = 256,
  parameter logic [15:0] DEV_CODE       = 16'h1505
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        init_start,
  output logic        init_done,
  output logic        init_fail,
  output logic        panel_rst_n,
  output logic        bus_valid,
  input  logic        bus_ready,
  output logic [1:0]  bus_op,
  output logic [17:0] bus_word,
  input  logic [17:0] bus_rdata
);

  typedef enum logic [2:0] {ST_IDLE, ST_STEP, ST_WAIT, ST_IDX, ST_DAT, ST_RD} state_e;

  state_e               state;
  logic [STEP_AW-1:0]   step_idx;
  logic [31:0]          rep_left;
  logic [TBL_AW-1:0]    tptr;
  logic                 prst_q, done_q, fail_q;

  step_t                ent;
  logic [15:0]          tbl_addr, tbl_val;
  logic [15:0]          cur_addr, cur_val;
  logic                 tmr_load, tmr_idle;
  logic                 hs;

  pis_step_rom #(
    .COLS(COLS), .ROWS(ROWS), .WORDS_PER_LINE(WORDS_PER_LINE)
  ) u_steps (
    .idx(step_idx),
    .ent(ent)
  );

  pis_table_rom u_table (
    .idx (tptr),
    .addr(tbl_addr),
    .val (tbl_val)
  );

  pis_ms_timer #(.CYC_PER_MS(CYC_PER_MS), .MS_W(MS_W)) u_timer (
    .clk  (clk),
    .rst_n(rst_n),
    .load (tmr_load),
    .ms   (ent.val[MS_W-1:0]),
    .idle (tmr_idle)
  );

  // pair currently being sent: from the table for table steps, else from the step
  always_comb begin
    if (ent.kind == SK_TABLE) begin
      cur_addr = tbl_addr;
      cur_val  = tbl_val;
    end else begin
      cur_addr = ent.addr;
      cur_val  = ent.val;
    end
  end

  assign tmr_load = (state == ST_STEP) &&
                    (ent.kind == SK_RST_LO || ent.kind == SK_RST_HI || ent.kind == SK_DELAY);

  assign bus_valid = (state == ST_IDX) || (state == ST_DAT) || (state == ST_RD);
  assign hs        = bus_valid && bus_ready;

  always_comb begin
    bus_op   = OP_IDX;
    bus_word = pack_bus(16'h0000);
    case (state)
      ST_IDX: begin
        bus_op   = OP_IDX;
        bus_word = (ent.kind == SK_IDX_ONLY) ? pack_bus(ent.val) : pack_bus(cur_addr);
      end
      ST_DAT: begin
        bus_op   = OP_DAT;
        bus_word = pack_bus(cur_val);
      end
      ST_RD: begin
        bus_op   = OP_RD;
        bus_word = pack_bus(16'h0000);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      step_idx <= '0;
      rep_left <= '0;
      tptr     <= '0;
      prst_q   <= 1'b1;
      done_q   <= 1'b0;
      fail_q   <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (init_start) begin
            step_idx <= '0;
            done_q   <= 1'b0;
            fail_q   <= 1'b0;
            state    <= ST_STEP;
          end
        end
        ST_STEP: begin
          case (ent.kind)
            SK_RST_LO: begin
              prst_q <= 1'b0;
              state  <= ST_WAIT;
            end
            SK_RST_HI: begin
              prst_q <= 1'b1;
              state  <= ST_WAIT;
            end
            SK_DELAY: state <= ST_WAIT;
            SK_WRITE: begin
              rep_left <= ent.rep;
              state    <= ST_IDX;
            end
            SK_TABLE: begin
              rep_left <= ent.rep;
              tptr     <= ent.val[TBL_AW-1:0];
              state    <= ST_IDX;
            end
            SK_ID_READ, SK_IDX_ONLY: state <= ST_IDX;
            default: begin
              done_q <= 1'b1;
              state  <= ST_IDLE;
            end
          endcase
        end
        ST_WAIT: begin
          if (tmr_idle) begin
            step_idx <= step_idx + 1'b1;
            state    <= ST_STEP;
          end
        end
        ST_IDX: begin
          if (hs) begin
            if (ent.kind == SK_IDX_ONLY) begin
              step_idx <= step_idx + 1'b1;
              state    <= ST_STEP;
            end else if (ent.kind == SK_ID_READ) begin
              state <= ST_RD;
            end else begin
              state <= ST_DAT;
            end
          end
        end
        ST_DAT: begin
          if (hs) begin
            tptr <= tptr + 1'b1;
            if (rep_left <= 32'd1) begin
              step_idx <= step_idx + 1'b1;
              state    <= ST_STEP;
            end else begin
              rep_left <= rep_left - 32'd1;
              state    <= ST_IDX;
            end
          end
        end
        ST_RD: begin
          if (hs) begin
            if (unpack_bus(bus_rdata) == DEV_CODE) begin
              step_idx <= step_idx + 1'b1;
              state    <= ST_STEP;
            end else begin
              fail_q <= 1'b1;
              state  <= ST_IDLE;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign panel_rst_n = prst_q;
  assign init_done   = done_q;
  assign init_fail   = fail_q;

endmodule

// File: rtl/pis_checker.sv
module pis_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        init_start,
  input logic        init_done,
  input logic        init_fail,
  input logic        panel_rst_n,
  input logic        bus_valid,
  input logic        bus_ready,
  input logic [1:0]  bus_op,
  input logic [17:0] bus_word
);

  // R10
  payload_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_ready) |=> (bus_valid && $stable(bus_op) && $stable(bus_word)));

  // R3
  marker_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid |-> (bus_word[0] && bus_word[9] && bus_op != 2'd3));

  // R2
  reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !panel_rst_n |-> !bus_valid);

  // R4
  fail_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_fail |-> !bus_valid);

  // R11
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (init_done && !init_start) |=> init_done);

  // R11
  fail_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (init_fail && !init_start) |=> init_fail);

  // R11
  flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(init_done && init_fail));

endmodule

bind panel_init_seq pis_checker u_pis_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .init_start (init_start),
  .init_done  (init_done),
  .init_fail  (init_fail),
  .panel_rst_n(panel_rst_n),
  .bus_valid  (bus_valid),
  .bus_ready  (bus_ready),
  .bus_op     (bus_op),
  .bus_word   (bus_word)
);

// File: tb/panel_init_seq_bench.sv
module panel_init_seq_bench;
  localparam int CPM  = 4;
  localparam int COLS = 8;
  localparam int ROWS = 16;
  localparam int WPL  = 256;
  localparam logic [15:0] CODE = 16'h1505;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        init_start = 1'b0;
  logic        init_done, init_fail, panel_rst_n, bus_valid;
  logic        bus_ready = 1'b0;
  logic [1:0]  bus_op;
  logic [17:0] bus_word;
  logic [17:0] bus_rdata = '0;

  always #4 clk = ~clk;

  panel_init_seq #(
    .CYC_PER_MS(CPM), .COLS(COLS), .ROWS(ROWS), .WORDS_PER_LINE(WPL), .DEV_CODE(CODE)
  ) u_panel_init_seq (
    .clk(clk), .rst_n(rst_n), .init_start(init_start), .init_done(init_done),
    .init_fail(init_fail), .panel_rst_n(panel_rst_n), .bus_valid(bus_valid),
    .bus_ready(bus_ready), .bus_op(bus_op), .bus_word(bus_word), .bus_rdata(bus_rdata)
  );

  localparam logic [31:0] TBL [44] = '{
    32'h0060_2700, 32'h0008_0808, 32'h0090_001A, 32'h0007_0001, 32'h0017_0001, 32'h0019_0000,
    32'h0010_17B0, 32'h0011_0116, 32'h0012_0198, 32'h0013_1400, 32'h0029_000C, 32'h0012_01B8,
    32'h0030_0307, 32'h0031_0303, 32'h0032_0603, 32'h0033_0202, 32'h0034_0202, 32'h0035_0202,
    32'h0036_1F1F, 32'h0037_0303, 32'h0038_0303, 32'h0039_0603, 32'h003A_0202, 32'h003B_0102,
    32'h003C_0204, 32'h003D_0000, 32'h0001_0100, 32'h0002_0300, 32'h0003_5028, 32'h0020_00EF,
    32'h0021_0000, 32'h0004_0000, 32'h0009_0000, 32'h000A_0008, 32'h000C_0000, 32'h000D_0000,
    32'h0015_8000, 32'h0061_0001, 32'h0092_0100, 32'h0093_0001, 32'h0007_0021, 32'h0010_16B0,
    32'h0011_0111, 32'h0007_0061};

  int n_chk = 0, n_fail = 0, cyc = 0;
  int ready_mode = 0;
  logic [15:0] rd_code = CODE;

  logic [1:0]  e_op[$];
  logic [17:0] e_word[$];
  int          dly_at[$], dly_ms[$];
  logic [1:0]  l_op[$];
  logic [17:0] l_word[$];
  int          hs_cyc[$];
  int          stream_err = 0, rst_lo_cnt = 0, rst_rise = 0, done_rise = 0;
  int          idx_a4 = 0, idx_win = 0;
  logic        prst_prev = 1'b1, done_prev = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [17:0] bmap(input logic [15:0] w);
    return {w[15:8], 1'b1, w[7:0], 1'b1};
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, what, act, act, exp, exp);
    end
  endtask

  task automatic e_wr(input logic [15:0] a, input logic [15:0] v);
    e_op.push_back(2'd0); e_word.push_back(bmap(a));
    e_op.push_back(2'd1); e_word.push_back(bmap(v));
  endtask

  task automatic mark(input int ms);
    dly_at.push_back(e_op.size() - 1);
    dly_ms.push_back(ms);
  endtask

  task automatic e_tbl(input int first, input int n);
    for (int i = first; i < first + n; i++) e_wr(TBL[i][31:16], TBL[i][15:0]);
  endtask

  task automatic build_expected();
    e_op.delete(); e_word.delete(); dly_at.delete(); dly_ms.delete();
    for (int i = 0; i < 4; i++) e_wr(16'h0, 16'h0);
    e_op.push_back(2'd0); e_word.push_back(bmap(16'h0));
    e_op.push_back(2'd2); e_word.push_back(18'h0);
    for (int i = 0; i < 4; i++) e_wr(16'h0, 16'h0);
    e_wr(16'h00A4, 16'h0001); idx_a4 = e_op.size() - 1; mark(10);
    e_tbl(0, 12);  mark(100);
    e_tbl(12, 25); mark(0);
    idx_win = e_op.size() + 1;
    e_wr(16'h0050, 16'(239 - (ROWS - 1)));
    e_wr(16'h0051, 16'h00EF);
    e_wr(16'h0052, 16'h0000);
    e_wr(16'h0053, 16'(COLS - 1));
    e_tbl(37, 4); mark(10);
    e_tbl(41, 3); mark(40);
    e_wr(16'h0020, 16'h0); e_wr(16'h0021, 16'h0);
    for (int i = 0; i < COLS * WPL; i++) e_wr(16'h0022, 16'h0);
    e_wr(16'h0020, 16'h0); e_wr(16'h0021, 16'h0);
    e_wr(16'h0007, 16'h0173); mark(40);
    e_op.push_back(2'd0); e_word.push_back(bmap(16'h0022));
  endtask

  // bus responder and monitors, all acting at the falling edge
  initial begin
    forever begin
      @(negedge clk);
      if (!panel_rst_n) rst_lo_cnt++;
      if (panel_rst_n && !prst_prev) rst_rise = cyc;
      prst_prev = panel_rst_n;
      if (init_done && !done_prev) done_rise = cyc;
      done_prev = init_done;
      bus_ready = (ready_mode == 0) ? 1'b1 : ((cyc % 3) != 1);
      bus_rdata = {rd_code[15:8], 1'b0, rd_code[7:0], 1'b0};
      if (bus_valid && bus_ready) begin
        int n;
        n = l_op.size();
        l_op.push_back(bus_op); l_word.push_back(bus_word); hs_cyc.push_back(cyc);
        if (n >= e_op.size()) stream_err++;
        else if (bus_op != e_op[n] || (bus_op != 2'd2 && bus_word != e_word[n])) begin
          if (stream_err == 0)
            $display("note: first stream mismatch at transfer %0d: op %0d word 0x%0h, expected op %0d word 0x%0h",
                     n, bus_op, bus_word, e_op[n], e_word[n]);
          stream_err++;
        end
      end
    end
  end

  task automatic clear_logs();
    l_op.delete(); l_word.delete(); hs_cyc.delete();
    stream_err = 0; rst_lo_cnt = 0; rst_rise = 0; done_rise = 0;
  endtask

  task automatic pulse_start();
    @(negedge clk); init_start = 1'b1;
    @(negedge clk); init_start = 1'b0;
  endtask

  task automatic wait_end();
    for (int i = 0; i < 40000; i++) begin
      @(negedge clk);
      if (init_done || init_fail) break;
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(init_done == 1'b0, "R1", "done after reset", int'(init_done), 0);
    chk(init_fail == 1'b0, "R1", "fail after reset", int'(init_fail), 0);
    chk(panel_rst_n == 1'b1, "R1", "panel reset after reset", int'(panel_rst_n), 1);
    chk(bus_valid == 1'b0, "R1", "valid after reset", int'(bus_valid), 0);
  endtask

  task automatic t_full_run(input int mode, input bit poke_busy);
    int fills;
    ready_mode = mode; rd_code = CODE;
    build_expected(); clear_logs();
    pulse_start();
    @(negedge clk);
    chk(init_done == 1'b0 && init_fail == 1'b0, "R11", "flags cleared by start",
        int'({init_done, init_fail}), 0);
    if (poke_busy) begin
      repeat (600) @(negedge clk);
      pulse_start();
    end
    wait_end();
    chk(init_done == 1'b1 && init_fail == 1'b0, "R9", "done at end", int'({init_done, init_fail}), 2);
    chk(stream_err == 0, "R5", "transfer order mismatches", stream_err, 0);
    chk(l_op.size() == e_op.size(), "R5", "transfer count", l_op.size(), e_op.size());
    chk(rst_lo_cnt >= 2 * CPM && rst_lo_cnt <= 2 * CPM + 4, "R2", "reset low cycles", rst_lo_cnt, 2 * CPM);
    if (l_op.size() == e_op.size()) begin
      chk(hs_cyc[0] - rst_rise >= CPM && hs_cyc[0] - rst_rise <= CPM + 8, "R2",
          "reset release to first transfer", hs_cyc[0] - rst_rise, CPM);
      chk(l_op[8] == 2'd0 && l_op[9] == 2'd2, "R4", "identity read after first sync",
          int'({l_op[8], l_op[9]}), 2);
      chk(l_word[idx_a4 - 1] == 18'h00349, "R3", "mapped index 0x00A4", int'(l_word[idx_a4 - 1]), 32'h349);
      chk(l_word[idx_win] == 18'h003C1, "R7", "window top value", int'(l_word[idx_win]), 32'h3C1);
      chk(l_word[idx_win + 6] == 18'h0020F, "R7", "window right value", int'(l_word[idx_win + 6]), 32'h20F);
      fills = 0;
      for (int i = 0; i + 1 < l_op.size(); i++)
        if (l_op[i] == 2'd0 && l_word[i] == bmap(16'h0022) && l_op[i + 1] == 2'd1) fills++;
      chk(fills == COLS * WPL, "R8", "memory clear writes", fills, COLS * WPL);
      for (int k = 0; k < dly_at.size(); k++) begin
        int gap;
        gap = hs_cyc[dly_at[k] + 1] - hs_cyc[dly_at[k]];
        chk(gap >= dly_ms[k] * CPM && gap <= dly_ms[k] * CPM + 8, "R6", "pause after group",
            gap, dly_ms[k] * CPM);
      end
      chk(l_op[l_op.size() - 1] == 2'd0 && l_word[l_word.size() - 1] == 18'h00245, "R9",
          "closing index-only word", int'(l_word[l_word.size() - 1]), 32'h245);
      chk(done_rise - hs_cyc[hs_cyc.size() - 1] >= 100 * CPM &&
          done_rise - hs_cyc[hs_cyc.size() - 1] <= 100 * CPM + 8, "R9", "final pause",
          done_rise - hs_cyc[hs_cyc.size() - 1], 100 * CPM);
    end
    repeat (20) @(negedge clk);
    chk(init_done == 1'b1 && bus_valid == 1'b0, "R11", "done held while idle", int'(init_done), 1);
  endtask

  task automatic t_bad_code();
    ready_mode = 0; rd_code = 16'h1504;
    build_expected(); clear_logs();
    pulse_start();
    wait_end();
    chk(init_fail == 1'b1 && init_done == 1'b0, "R4", "fail on wrong code", int'({init_done, init_fail}), 1);
    repeat (50) @(negedge clk);
    chk(l_op.size() == 10, "R4", "transfers up to and including the read", l_op.size(), 10);
    chk(init_fail == 1'b1, "R11", "fail held", int'(init_fail), 1);
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_full_run(0, 1'b0);
    t_bad_code();
    t_full_run(1, 1'b1);
    finish_up();
  end
endmodule